// File: doc/BRIEF.md
# SPI Master Interrupt Status Controller

This block gathers the interrupt sources of a FIFO-based SPI master and turns them into one level-sensitive interrupt line. Three sources are transient events: a transmit underflow, a receive overflow and a mode fault. Each arrives as a one-cycle pulse and is captured in a sticky status bit. Four sources follow FIFO state and are recomputed every cycle: receive full, transmit full, and two threshold comparisons against programmable levels. A mask register selects which status bits may raise the interrupt. The mask is changed only through separate set and clear registers.

Software uses a small word-addressed register port. The read strobe lets a status read clear the sticky bits. Writing ones to the status register clears only the chosen sticky bits. While the controller runs in linear (memory-mapped) read mode, the status register and the interrupt line are frozen.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset the status reads 0, the mask reads 0, both thresholds read 1 and irq_o is low.
- R2: A pulse on tx_underflow_i, mode_fail_i or rx_overflow_i sets status bit 6, 1 or 0 on the next clock edge. The bit stays set until software clears it.
- R3: Status bit 5 is 1 when rx_level_i equals DEPTH, and bit 3 is 1 when tx_level_i equals DEPTH. Both are recomputed on every clock edge.
- R4: Status bit 4 is 1 when rx_level_i is greater than or equal to the receive threshold. Status bit 2 is 1 when tx_level_i is strictly less than the transmit threshold. Both are recomputed on every clock edge.
- R5: Writing address 1 ORs wdata_i[6:0] into the mask, and writing address 2 clears the mask bits that are 1 in wdata_i[6:0]. Address 3 returns the mask and ignores writes. Addresses 1 and 2 read as 0.
- R6: Writing address 0 clears each sticky bit (6, 1, 0) whose wdata_i bit is 1, and leaves the other sticky bits unchanged.
- R7: rd_i asserted with address 0 clears all sticky bits on that edge. rdata_o returns the status value that held before the clear.
- R8: When a sticky event arrives in the same cycle as a read-clear or a write-clear of its bit, the bit stays set.
- R9: irq_o is registered. After each edge without linear mode, it equals the OR of (status AND mask) as they stood before that edge.
- R10: While lin_read_i is 1, the status register and irq_o hold their values. Events, clears and FIFO level changes are ignored. The mask and thresholds remain writable.
- R11: The transmit threshold at address 4 and the receive threshold at address 5 are written from wdata_i[LVL_W-1:0] and read back zero-extended. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Word address of register access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (enables read-to-clear) |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| tx_level_i | input | LVL_W | Transmit FIFO fill level, 0..DEPTH |
| rx_level_i | input | LVL_W | Receive FIFO fill level, 0..DEPTH |
| tx_underflow_i | input | 1 | Transmit underflow event pulse |
| rx_overflow_i | input | 1 | Receive overflow event pulse |
| mode_fail_i | input | 1 | Mode fault event pulse |
| lin_read_i | input | 1 | Linear read mode active; freezes status and interrupt |
| irq_o | output | 1 | Level interrupt output |

## Verification
The assertions assume that the FIFO level inputs never exceed DEPTH and that every input is driven to a known value from the first clock. The stimulus draws levels only from 0 to DEPTH. It draws thresholds from the full LVL_W range, so the threshold bits also see values of zero and values above DEPTH. Events, linear mode and register strobes are drawn independently with moderate probability. This makes coincidences such as an event during a clear, or a strobe during the freeze, occur often in addition to the directed cases.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int STAT_W   = 7;
  localparam int N_STICKY = 3;
  localparam int ADDR_W   = 3;

  localparam int B_TX_UF   = 6;
  localparam int B_RX_FULL = 5;
  localparam int B_RX_NE   = 4;
  localparam int B_TX_FULL = 3;
  localparam int B_TX_NF   = 2;
  localparam int B_MODE_F  = 1;
  localparam int B_RX_OF   = 0;

  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DISABLE = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK    = 3'd3;
  localparam logic [ADDR_W-1:0] A_TX_THR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RX_THR  = 3'd5;

  // sticky index -> status bit position
  function automatic int sticky_pos(input int idx);
    case (idx)
      0:       return B_RX_OF;
      1:       return B_MODE_F;
      default: return B_TX_UF;
    endcase
  endfunction
endpackage

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= 1'b0;
    else if (!hold_i) q_q <= set_i | (q_q & ~clr_i);
  end

  assign q_o = q_q;

  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && set_i) |=> q_o); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && clr_i && !set_i) |=> !q_o); // R6
  AST_STICKY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o); // R2
endmodule

// File: rtl/spi_irq_level.sv
module spi_irq_level #(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  output logic             rx_full_o,
  output logic             rx_ne_o,
  output logic             tx_full_o,
  output logic             tx_nf_o
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [3:0] flags_d, flags_q;

  always_comb begin
    flags_d[3] = (rx_level_i == FULL_LVL);
    flags_d[2] = (rx_level_i >= rx_thr_i);
    flags_d[1] = (tx_level_i == FULL_LVL);
    flags_d[0] = (tx_level_i <  tx_thr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= '0;
    else if (!hold_i) flags_q <= flags_d;
  end

  assign {rx_full_o, rx_ne_o, tx_full_o, tx_nf_o} = flags_q;

  AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_i <= FULL_LVL) && (rx_level_i <= FULL_LVL)); // R3
  AST_RX_EMPTY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && rx_level_i == '0 && rx_thr_i != '0) |=> !rx_ne_o); // R4
  AST_TX_FULL_NF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && tx_level_i == FULL_LVL && tx_thr_i <= FULL_LVL) |=> (tx_full_o && !tx_nf_o)); // R3
endmodule

// File: rtl/spi_irq_cfg.sv
module spi_irq_cfg
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [STAT_W-1:0] mask_o,
  output logic [LVL_W-1:0]  tx_thr_o,
  output logic [LVL_W-1:0]  rx_thr_o
);
  localparam logic [LVL_W-1:0] THR_RST = LVL_W'(1);

  logic [STAT_W-1:0] mask_q;
  logic [LVL_W-1:0]  tx_thr_q, rx_thr_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      tx_thr_q <= THR_RST;
      rx_thr_q <= THR_RST;
    end else if (wr_i) begin
      case (addr_i)
        A_ENABLE:  mask_q   <= mask_q | wdata_i[STAT_W-1:0];
        A_DISABLE: mask_q   <= mask_q & ~wdata_i[STAT_W-1:0];
        A_TX_THR:  tx_thr_q <= wdata_i[LVL_W-1:0];
        A_RX_THR:  rx_thr_q <= wdata_i[LVL_W-1:0];
        default: ;
      endcase
    end
  end

  assign mask_o   = mask_q;
  assign tx_thr_o = tx_thr_q;
  assign rx_thr_o = rx_thr_q;

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_ENABLE) |=>
      ((mask_o & $past(wdata_i[STAT_W-1:0])) == $past(wdata_i[STAT_W-1:0]))); // R5
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_DISABLE) |=> ((mask_o & $past(wdata_i[STAT_W-1:0])) == '0)); // R5
  AST_MASK_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_MASK) |=> $stable(mask_o)); // R5
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic              tx_underflow_i,
  input  logic              rx_overflow_i,
  input  logic              mode_fail_i,
  input  logic              lin_read_i,
  output logic              irq_o
);
  logic [STAT_W-1:0]   status, mask;
  logic [LVL_W-1:0]    tx_thr, rx_thr;
  logic [N_STICKY-1:0] ev, sticky;
  logic                rd_clr, wr_clr;
  logic                irq_q;

  assign ev     = {tx_underflow_i, mode_fail_i, rx_overflow_i};
  assign rd_clr = rd_i && (addr_i == A_STATUS);
  assign wr_clr = wr_i && (addr_i == A_STATUS);

  spi_irq_cfg #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_cfg (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .mask_o(mask), .tx_thr_o(tx_thr), .rx_thr_o(rx_thr)
  );

  for (genvar j = 0; j < N_STICKY; j++) begin : g_sticky
    localparam int POS = sticky_pos(j);
    spi_irq_sticky u_bit (
      .clk_i, .rst_ni,
      .hold_i(lin_read_i),
      .set_i (ev[j]),
      .clr_i (rd_clr | (wr_clr & wdata_i[POS])),
      .q_o   (sticky[j])
    );
    assign status[POS] = sticky[j];
  end

  spi_irq_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
    .clk_i, .rst_ni,
    .hold_i    (lin_read_i),
    .tx_level_i, .rx_level_i,
    .tx_thr_i  (tx_thr),
    .rx_thr_i  (rx_thr),
    .rx_full_o (status[B_RX_FULL]),
    .rx_ne_o   (status[B_RX_NE]),
    .tx_full_o (status[B_TX_FULL]),
    .tx_nf_o   (status[B_TX_NF])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          irq_q <= 1'b0;
    else if (!lin_read_i) irq_q <= |(status & mask);
  end

  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_STATUS: rdata_o[STAT_W-1:0] = status;
      A_MASK:   rdata_o[STAT_W-1:0] = mask;
      A_TX_THR: rdata_o[LVL_W-1:0]  = tx_thr;
      A_RX_THR: rdata_o[LVL_W-1:0]  = rx_thr;
      default: ;
    endcase
  end

  AST_IRQ_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(lin_read_i) |-> (irq_o == |($past(status & mask)))); // R9
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lin_read_i |=> ($stable(status) && $stable(irq_o))); // R10
  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && !lin_read_i && ev == '0) |=> (sticky == '0)); // R7
endmodule

// File: tb/spi_irq_ctrl_bench.sv
module spi_irq_ctrl_bench;
  localparam int DEPTH = 32;
  localparam int LVL_W = 6;
  localparam int DW    = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr = 0, rd = 0, tx_uf = 0, rx_of = 0, mf = 0, lin = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [LVL_W-1:0] tx_lvl = '0, rx_lvl = '0;
  logic irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [6:0] m_stat = '0, m_mask = '0;
  logic [LVL_W-1:0] m_txt = 1, m_rxt = 1;
  logic m_irq = 0;

  always #5 clk = ~clk;

  spi_irq_ctrl #(.DEPTH(DEPTH), .DATA_W(DW)) u_spi_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .tx_level_i(tx_lvl), .rx_level_i(rx_lvl),
    .tx_underflow_i(tx_uf), .rx_overflow_i(rx_of), .mode_fail_i(mf),
    .lin_read_i(lin), .irq_o(irq)
  );

  function automatic logic [DW-1:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return DW'(m_stat);
      3'd3: return DW'(m_mask);
      3'd4: return DW'(m_txt);
      3'd5: return DW'(m_rxt);
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // model update on the edge, from pre-edge state and inputs
  task automatic model_edge();
    logic [6:0] clr, evv, lvl;
    if (!lin) begin
      m_irq = |(m_stat & m_mask);
      clr = (rd && addr == 0) ? 7'h7f : ((wr && addr == 0) ? wdata[6:0] : 7'h00);
      evv = {tx_uf, 4'b0, mf, rx_of};
      lvl = '0;
      lvl[5] = (rx_lvl == LVL_W'(DEPTH));
      lvl[4] = (rx_lvl >= m_rxt);
      lvl[3] = (tx_lvl == LVL_W'(DEPTH));
      lvl[2] = (tx_lvl < m_txt);
      m_stat = evv | (m_stat & 7'h43 & ~clr) | lvl;
    end
    if (wr) begin
      case (addr)
        3'd1: m_mask = m_mask | wdata[6:0];
        3'd2: m_mask = m_mask & ~wdata[6:0];
        3'd4: m_txt = wdata[LVL_W-1:0];
        3'd5: m_rxt = wdata[LVL_W-1:0];
        default: ;
      endcase
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, "irq", DW'(irq), DW'(m_irq));
    check(tag, "rdata", rdata, exp_rd(addr));
    wr = 0; rd = 0; tx_uf = 0; rx_of = 0; mf = 0;
  endtask

  task automatic peek(input logic [2:0] a, input string tag);
    addr = a;
    #1;
    check(tag, "peek", rdata, exp_rd(a));
  endtask

  task automatic wreg(input logic [2:0] a, input logic [DW-1:0] d, input string tag);
    addr = a; wr = 1; wdata = d;
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1", "irq", DW'(irq), '0);
    peek(3'd0, "R1"); peek(3'd3, "R1"); peek(3'd4, "R1"); peek(3'd5, "R1");
    rst_n = 1;
    @(negedge clk);
    check("R1", "irq after release", DW'(irq), '0);

    // R11 thresholds and unused addresses
    wreg(3'd4, 32'hFFFF_FF03, "R11");
    wreg(3'd5, 32'h0000_0005, "R11");
    peek(3'd4, "R11"); peek(3'd5, "R11"); peek(3'd6, "R11"); peek(3'd7, "R11");

    // R4 threshold compares
    addr = 0; rx_lvl = 5; tx_lvl = 2; tick("R4");
    check("R4", "rx_ne/tx_nf set", DW'(rdata[4] & rdata[2]), 1);
    rx_lvl = 4; tx_lvl = 3; tick("R4");
    check("R4", "rx_ne/tx_nf clear", DW'(rdata[4] | rdata[2]), 0);

    // R3 full flags
    rx_lvl = 32; tx_lvl = 32; tick("R3");
    check("R3", "full bits", DW'({rdata[5], rdata[3]}), 3);
    rx_lvl = 31; tx_lvl = 0; tick("R3");
    check("R3", "full bits cleared", DW'({rdata[5], rdata[3]}), 0);

    // R2 sticky events
    tx_uf = 1; tick("R2");
    mf = 1; rx_of = 1; tick("R2");
    tick("R2");
    check("R2", "sticky held", DW'({rdata[6], rdata[1], rdata[0]}), 7);

    // R6 write-one-to-clear
    wreg(3'd0, 32'h0000_0041, "R6");
    check("R6", "w1c", DW'({rdata[6], rdata[1], rdata[0]}), 3'b010);

    // R7 read-to-clear
    tx_uf = 1; tick("R7");
    addr = 0; rd = 1; tick("R7");
    check("R7", "rd clear", DW'({rdata[6], rdata[1], rdata[0]}), 0);

    // R8 event beats clear
    rd = 1; mf = 1; tick("R8");
    wr = 1; wdata = 32'h7F; rx_of = 1; tick("R8");
    check("R8", "event wins", DW'({rdata[1], rdata[0]}), 3'b01);

    // R5 mask set/clear/read-only
    wreg(3'd1, 32'hFFFF_FF7F, "R5");
    wreg(3'd2, 32'h0000_0005, "R5");
    peek(3'd3, "R5");
    check("R5", "mask value", rdata, 32'h7A);
    wreg(3'd3, 32'h0, "R5");
    peek(3'd3, "R5"); peek(3'd1, "R5"); peek(3'd2, "R5");

    // R9 interrupt from mask and status
    wreg(3'd2, 32'h7F, "R9");
    wreg(3'd0, 32'h7F, "R9");
    tick("R9");
    check("R9", "irq low masked", DW'(irq), 0);
    wreg(3'd1, 32'h40, "R9");
    tx_uf = 1; tick("R9");
    tick("R9");
    check("R9", "irq high", DW'(irq), 1);

    // R10 freeze
    lin = 1; addr = 0; rd = 1; tick("R10");
    mf = 1; rx_lvl = 32; tick("R10");
    wreg(3'd2, 32'h40, "R10");
    check("R10", "irq frozen", DW'(irq), 1);
    peek(3'd0, "R10");
    lin = 0; tick("R10");
    tick("R10");
    check("R10", "irq after thaw", DW'(irq), 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      addr   = 3'($urandom % 8);
      wr     = ($urandom % 4) == 0;
      rd     = ($urandom % 5) == 0;
      wdata  = $urandom;
      tx_lvl = LVL_W'($urandom % (DEPTH + 1));
      rx_lvl = LVL_W'($urandom % (DEPTH + 1));
      tx_uf  = ($urandom % 6) == 0;
      rx_of  = ($urandom % 6) == 0;
      mf     = ($urandom % 8) == 0;
      lin    = ($urandom % 10) == 0;
      tick("RND");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule